// File: doc/BRIEF.md
# Multiplexed Bus Slave Transfer Decoder

This block is the responding side of a parallel bus on which one set of eight lines carries addresses and data in turn. A second set of eight lines can carry the upper address octet. Every control line idles high and is asserted low. The block brings all the strobes into its own clock domain. It detects the moment each strobe returns high, and it samples the shared lines at that moment. From the order of the phases it decides whether the unit is currently selected.

A matching address puts the unit into an active session. While the session lasts, the unit can latch an internal sub-address, such as a channel or timeslot selector. It then takes part in data phases. In a write data phase it captures the octet and gives a one-cycle strobe to local logic. In a read data phase it drives a local octet through an output enable. The session ends only through the order of the phases, or when a release or arbitration line is pulled low. There is no end-of-transfer signal.

Top module: `mbus_slave_decoder`

## Requirements
- R1: While reset is applied and right after it, `sel_active`, `sub_valid`, `wr_strobe`, `rd_done` and `bus_da_oe` are all 0.
- R2: When an address phase ends and the previous phase was a data phase or there was no previous phase, `sel_active` takes the result of the address compare. With `WIDE_ADDR`=1 the compare is `{bus_hi_addr, bus_da_in}` == `UNIT_ADDR`. With `WIDE_ADDR`=0 it is `bus_da_in` == `UNIT_ADDR[7:0]`, and `bus_hi_addr` is ignored.
- R3: Over back-to-back address phases (address following address), the unit stays active if any one of them matched.
- R4: At the end of an internal-address phase, an active unit loads `bus_da_in` into `sub_addr` and sets `sub_valid`. An inactive unit leaves `sub_valid` at 0. `sub_valid` is never 1 while `sel_active` is 0.
- R5: When a data phase ends with `bus_wr_n`=0 on an active unit, `wr_octet` takes `bus_da_in` and `wr_strobe` is 1 for exactly one cycle. An inactive unit gives no strobe. `wr_octet` changes only together with `wr_strobe`.
- R6: `bus_da_oe` is 1 exactly while the unit is active, the synchronized `bus_ds_n` is 0 and the synchronized `bus_wr_n` is 1. While `bus_da_oe` is 1, `bus_da_out` equals `rd_octet`.
- R7: An address phase that follows a data phase starts a new sequence. It clears `sub_valid`, and a non-matching address clears `sel_active`.
- R8: An internal-address phase that follows a data phase replaces the internal address. The unit stays active, and later data phases go to the new `sub_addr`.
- R9: A low level on `bus_release_n` or on `arb_request_n` clears `sel_active` and `sub_valid` one cycle after the synchronized falling edge is seen.
- R10: With `READ_EN`=0 the unit never asserts `bus_da_oe`. With `WRITE_EN`=0 it never gives `wr_strobe`. Both hold even while the unit is active.
- R11: A result caused by a strobe returning high appears on the third rising clock edge after that return, with `SYNC_STAGES`=2. The shared lines are sampled on that same edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| bus_as_n | input | 1 | Address strobe, active low |
| bus_ias_n | input | 1 | Internal-address strobe, active low |
| bus_ds_n | input | 1 | Data strobe, active low |
| bus_wr_n | input | 1 | Write qualifier, low for a write |
| bus_release_n | input | 1 | Forced release of bus sessions, active low |
| arb_request_n | input | 1 | New arbitration request, active low |
| bus_da_in | input | 8 | Shared data/address lines as received |
| bus_hi_addr | input | 8 | Upper address octet lines |
| bus_da_out | output | 8 | Octet to drive onto the shared lines |
| bus_da_oe | output | 1 | Output enable for the shared lines |
| rd_octet | input | 8 | Local octet to return in read phases |
| sel_active | output | 1 | Unit is in its active session |
| sub_valid | output | 1 | An internal address is held |
| sub_addr | output | 8 | Held internal address |
| wr_octet | output | 8 | Last captured write octet |
| wr_strobe | output | 1 | One-cycle pulse when a write octet is captured |
| rd_done | output | 1 | One-cycle pulse when a read phase of the active unit ends |

## Verification
Session state, the internal address and write captures are all due on the third rising edge after the strobe goes back high: two synchronizer edges, then the registered update. The output enable follows the synchronized data strobe two edges after it falls. The bench drives on falling edges and holds the shared lines for four cycles after each strobe returns. It therefore reads every level result at least three edges after the cause, and one address phase is probed at each falling edge to pin the exact edge. Write octets are queued when the data phase is driven and popped by a monitor on the falling edge that follows the strobe pulse, so an early, late, extra or missing capture is reported.

// File: rtl/mbus_pkg.sv
package mbus_pkg;

  // Phase last seen on the bus, used to decide session boundaries.
  typedef enum logic [1:0] {
    PH_IDLE  = 2'd0,
    PH_ADDR  = 2'd1,
    PH_IADDR = 2'd2,
    PH_DATA  = 2'd3
  } phase_t;

  // Positions of the control lines in the synchronizer vector.
  localparam int STB_AS    = 0;
  localparam int STB_IAS   = 1;
  localparam int STB_DS    = 2;
  localparam int STB_WR    = 3;
  localparam int STB_REL   = 4;
  localparam int STB_ARB   = 5;
  localparam int STB_COUNT = 6;

endpackage

// File: rtl/mbus_strobe_sync.sv
// Brings one active-low control line into the clock domain and flags
// its edges. The line idles high, so every stage resets to 1.
module mbus_strobe_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic line_n,
  output logic level_n,
  output logic rise,
  output logic fall
);

  logic [STAGES-1:0] pipe_q;
  logic [STAGES-1:0] pipe_d;
  logic              prev_q;

  always_comb begin
    pipe_d[0] = line_n;
    for (int i = 1; i < STAGES; i++) begin
      pipe_d[i] = pipe_q[i-1];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pipe_q <= '1;
      prev_q <= 1'b1;
    end else begin
      pipe_q <= pipe_d;
      prev_q <= pipe_q[STAGES-1];
    end
  end

  assign level_n = pipe_q[STAGES-1];
  assign rise    = level_n & ~prev_q;
  assign fall    = ~level_n & prev_q;

endmodule

// File: rtl/mbus_addr_match.sv
// Compares the bus address with the unit address, 8 or 16 bits wide.
module mbus_addr_match #(
  parameter logic [15:0] UNIT_ADDR = 16'h0000,
  parameter bit          WIDE_ADDR = 1'b1
) (
  input  logic [7:0] lo_octet,
  input  logic [7:0] hi_octet,
  output logic       hit
);

  generate
    if (WIDE_ADDR) begin : g_wide
      assign hit = ({hi_octet, lo_octet} == UNIT_ADDR);
    end else begin : g_narrow
      logic unused_hi;
      assign unused_hi = ^hi_octet;
      assign hit       = (lo_octet == UNIT_ADDR[7:0]);
    end
  endgenerate

endmodule

// File: rtl/mbus_session.sv
// Phase-order tracker: decides when the unit is selected and when the
// internal address is held, and issues the per-phase actions.
module mbus_session
  import mbus_pkg::*;
#(
  parameter bit READ_EN  = 1'b1,
  parameter bit WRITE_EN = 1'b1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic as_rise,
  input  logic ias_rise,
  input  logic ds_rise,
  input  logic clr_evt,
  input  logic wr_level_n,
  input  logic addr_hit,
  output logic active_q,
  output logic sub_valid_q,
  output logic sub_load,
  output logic wr_go,
  output logic rd_go
);

  phase_t last_q, last_d;
  logic   active_d;
  logic   sub_valid_d;

  always_comb begin
    active_d    = active_q;
    sub_valid_d = sub_valid_q;
    last_d      = last_q;
    sub_load    = 1'b0;
    wr_go       = 1'b0;
    rd_go       = 1'b0;
    if (clr_evt) begin
      active_d    = 1'b0;
      sub_valid_d = 1'b0;
      last_d      = PH_IDLE;
    end else if (as_rise) begin
      if (last_q == PH_ADDR) begin
        active_d = active_q | addr_hit;
      end else begin
        active_d    = addr_hit;
        sub_valid_d = 1'b0;
      end
      last_d = PH_ADDR;
    end else if (ias_rise) begin
      if (active_q) begin
        sub_load    = 1'b1;
        sub_valid_d = 1'b1;
      end
      last_d = PH_IADDR;
    end else if (ds_rise) begin
      if (active_q) begin
        wr_go = WRITE_EN & ~wr_level_n;
        rd_go = READ_EN & wr_level_n;
      end
      last_d = PH_DATA;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active_q    <= 1'b0;
      sub_valid_q <= 1'b0;
      last_q      <= PH_IDLE;
    end else begin
      active_q    <= active_d;
      sub_valid_q <= sub_valid_d;
      last_q      <= last_d;
    end
  end

endmodule

// File: rtl/mbus_datapath.sv
// Octet registers and the read drive toward the shared lines.
module mbus_datapath #(
  parameter int  DW      = 8,
  parameter bit  READ_EN = 1'b1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [DW-1:0] da_in,
  input  logic [DW-1:0] rd_octet,
  input  logic          active,
  input  logic          ds_level_n,
  input  logic          wr_level_n,
  input  logic          wr_go,
  input  logic          rd_go,
  input  logic          sub_load,
  output logic [DW-1:0] wr_octet,
  output logic          wr_strobe,
  output logic          rd_done,
  output logic [DW-1:0] sub_addr,
  output logic [DW-1:0] da_out,
  output logic          da_oe
);

  logic [DW-1:0] wr_octet_d;
  logic [DW-1:0] sub_addr_d;

  always_comb begin
    wr_octet_d = wr_go    ? da_in : wr_octet;
    sub_addr_d = sub_load ? da_in : sub_addr;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_octet  <= '0;
      sub_addr  <= '0;
      wr_strobe <= 1'b0;
      rd_done   <= 1'b0;
    end else begin
      wr_octet  <= wr_octet_d;
      sub_addr  <= sub_addr_d;
      wr_strobe <= wr_go;
      rd_done   <= rd_go;
    end
  end

  assign da_oe  = READ_EN & active & ~ds_level_n & wr_level_n;
  assign da_out = da_oe ? rd_octet : '0;

endmodule

// File: rtl/mbus_slave_decoder.sv
module mbus_slave_decoder
  import mbus_pkg::*;
#(
  parameter logic [15:0] UNIT_ADDR   = 16'h12A5,
  parameter bit          WIDE_ADDR   = 1'b1,
  parameter bit          READ_EN     = 1'b1,
  parameter bit          WRITE_EN    = 1'b1,
  parameter int          SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       bus_as_n,
  input  logic       bus_ias_n,
  input  logic       bus_ds_n,
  input  logic       bus_wr_n,
  input  logic       bus_release_n,
  input  logic       arb_request_n,
  input  logic [7:0] bus_da_in,
  input  logic [7:0] bus_hi_addr,
  output logic [7:0] bus_da_out,
  output logic       bus_da_oe,
  input  logic [7:0] rd_octet,
  output logic       sel_active,
  output logic       sub_valid,
  output logic [7:0] sub_addr,
  output logic [7:0] wr_octet,
  output logic       wr_strobe,
  output logic       rd_done
);

  // Reset: asserted at once, released through two flops.
  logic [1:0] rst_pipe_q;
  logic       rst_core_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_pipe_q <= 2'b00;
    end else begin
      rst_pipe_q <= {rst_pipe_q[0], 1'b1};
    end
  end
  assign rst_core_n = rst_pipe_q[1];

  logic [STB_COUNT-1:0] lines_n;
  logic [STB_COUNT-1:0] lvl_n;
  logic [STB_COUNT-1:0] rise_v;
  logic [STB_COUNT-1:0] fall_v;

  assign lines_n[STB_AS]  = bus_as_n;
  assign lines_n[STB_IAS] = bus_ias_n;
  assign lines_n[STB_DS]  = bus_ds_n;
  assign lines_n[STB_WR]  = bus_wr_n;
  assign lines_n[STB_REL] = bus_release_n;
  assign lines_n[STB_ARB] = arb_request_n;

  generate
    for (genvar g = 0; g < STB_COUNT; g++) begin : g_sync
      mbus_strobe_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk     (clk),
        .rst_n   (rst_core_n),
        .line_n  (lines_n[g]),
        .level_n (lvl_n[g]),
        .rise    (rise_v[g]),
        .fall    (fall_v[g])
      );
    end
  endgenerate

  logic addr_hit;
  logic clr_evt;
  logic sub_load;
  logic wr_go;
  logic rd_go;
  logic unused_edges;

  assign clr_evt      = fall_v[STB_REL] | fall_v[STB_ARB];
  assign unused_edges = ^{fall_v[STB_AS], fall_v[STB_IAS], fall_v[STB_DS],
                          fall_v[STB_WR], rise_v[STB_WR], rise_v[STB_REL],
                          rise_v[STB_ARB], lvl_n[STB_AS], lvl_n[STB_IAS],
                          lvl_n[STB_REL], lvl_n[STB_ARB]};

  mbus_addr_match #(.UNIT_ADDR(UNIT_ADDR), .WIDE_ADDR(WIDE_ADDR)) u_match (
    .lo_octet (bus_da_in),
    .hi_octet (bus_hi_addr),
    .hit      (addr_hit)
  );

  mbus_session #(.READ_EN(READ_EN), .WRITE_EN(WRITE_EN)) u_session (
    .clk         (clk),
    .rst_n       (rst_core_n),
    .as_rise     (rise_v[STB_AS]),
    .ias_rise    (rise_v[STB_IAS]),
    .ds_rise     (rise_v[STB_DS]),
    .clr_evt     (clr_evt),
    .wr_level_n  (lvl_n[STB_WR]),
    .addr_hit    (addr_hit),
    .active_q    (sel_active),
    .sub_valid_q (sub_valid),
    .sub_load    (sub_load),
    .wr_go       (wr_go),
    .rd_go       (rd_go)
  );

  mbus_datapath #(.DW(8), .READ_EN(READ_EN)) u_dp (
    .clk        (clk),
    .rst_n      (rst_core_n),
    .da_in      (bus_da_in),
    .rd_octet   (rd_octet),
    .active     (sel_active),
    .ds_level_n (lvl_n[STB_DS]),
    .wr_level_n (lvl_n[STB_WR]),
    .wr_go      (wr_go),
    .rd_go      (rd_go),
    .sub_load   (sub_load),
    .wr_octet   (wr_octet),
    .wr_strobe  (wr_strobe),
    .rd_done    (rd_done),
    .sub_addr   (sub_addr),
    .da_out     (bus_da_out),
    .da_oe      (bus_da_oe)
  );

endmodule

// File: rtl/mbus_slave_decoder_chk.sv
module mbus_slave_decoder_chk #(
  parameter bit READ_EN  = 1'b1,
  parameter bit WRITE_EN = 1'b1
) (
  input logic       clk,
  input logic       rst_n,
  input logic       da_oe,
  input logic       sel_active,
  input logic       sub_valid,
  input logic       wr_strobe,
  input logic [7:0] wr_octet,
  input logic       clr_evt
);

  // R6
  oe_needs_active_chk: assert property (@(posedge clk) disable iff (!rst_n)
    da_oe |-> sel_active);

  // R5
  wr_needs_active_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_strobe |-> sel_active);

  // R5
  wr_single_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_strobe |=> !wr_strobe);

  // R5
  wr_octet_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_strobe |-> $stable(wr_octet));

  // R4
  sub_needs_active_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sub_valid |-> sel_active);

  // R9
  release_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
    clr_evt |=> (!sel_active && !sub_valid));

  generate
    if (!READ_EN) begin : g_no_read
      // R10
      no_read_drive_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sel_active |-> !da_oe);
    end
    if (!WRITE_EN) begin : g_no_write
      // R10
      no_write_take_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sel_active |-> !wr_strobe);
    end
  endgenerate

endmodule

bind mbus_slave_decoder mbus_slave_decoder_chk #(
  .READ_EN  (READ_EN),
  .WRITE_EN (WRITE_EN)
) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .da_oe      (bus_da_oe),
  .sel_active (sel_active),
  .sub_valid  (sub_valid),
  .wr_strobe  (wr_strobe),
  .wr_octet   (wr_octet),
  .clr_evt    (clr_evt)
);

// File: tb/mbus_slave_decoder_tb.sv
module mbus_slave_decoder_tb;

  localparam time CLK_PERIOD = 10ns;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       bus_as_n = 1'b1;
  logic       bus_ias_n = 1'b1;
  logic       bus_ds_n = 1'b1;
  logic       bus_wr_n = 1'b1;
  logic       bus_release_n = 1'b1;
  logic       arb_request_n = 1'b1;
  logic [7:0] bus_da_in = 8'h00;
  logic [7:0] bus_hi_addr = 8'h00;
  logic [7:0] rd_octet = 8'hE1;

  logic [7:0] m_da_out, m_sub_addr, m_wr_octet;
  logic       m_da_oe, m_active, m_sub_valid, m_wr_strobe, m_rd_done;
  logic [7:0] n_da_out, n_sub_addr, n_wr_octet;
  logic       n_da_oe, n_active, n_sub_valid, n_wr_strobe, n_rd_done;

  int checks = 0;
  int failures = 0;
  bit finished = 1'b0;
  logic [7:0] exp_q[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  mbus_slave_decoder #(.UNIT_ADDR(16'h12A5), .WIDE_ADDR(1'b1)) u_dut (
    .clk(clk), .rst_n(rst_n), .bus_as_n(bus_as_n), .bus_ias_n(bus_ias_n),
    .bus_ds_n(bus_ds_n), .bus_wr_n(bus_wr_n), .bus_release_n(bus_release_n),
    .arb_request_n(arb_request_n), .bus_da_in(bus_da_in), .bus_hi_addr(bus_hi_addr),
    .bus_da_out(m_da_out), .bus_da_oe(m_da_oe), .rd_octet(rd_octet),
    .sel_active(m_active), .sub_valid(m_sub_valid), .sub_addr(m_sub_addr),
    .wr_octet(m_wr_octet), .wr_strobe(m_wr_strobe), .rd_done(m_rd_done)
  );

  mbus_slave_decoder #(.UNIT_ADDR(16'h3C5A), .WIDE_ADDR(1'b0),
                       .READ_EN(1'b0), .WRITE_EN(1'b0)) u_nocap (
    .clk(clk), .rst_n(rst_n), .bus_as_n(bus_as_n), .bus_ias_n(bus_ias_n),
    .bus_ds_n(bus_ds_n), .bus_wr_n(bus_wr_n), .bus_release_n(bus_release_n),
    .arb_request_n(arb_request_n), .bus_da_in(bus_da_in), .bus_hi_addr(bus_hi_addr),
    .bus_da_out(n_da_out), .bus_da_oe(n_da_oe), .rd_octet(rd_octet),
    .sel_active(n_active), .sub_valid(n_sub_valid), .sub_addr(n_sub_addr),
    .wr_octet(n_wr_octet), .wr_strobe(n_wr_strobe), .rd_done(n_rd_done)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // Scoreboard monitor: pops one expected octet per write strobe.
  always @(negedge clk) begin
    if (rst_n && m_wr_strobe) begin
      if (exp_q.size() == 0) begin
        chk(1'b0, "R5 unexpected write strobe", m_wr_octet, 0);
      end else begin
        automatic logic [7:0] e = exp_q.pop_front();
        chk(m_wr_octet == e, "R5 write octet", m_wr_octet, e);
      end
    end
    if (rst_n && n_wr_strobe) chk(1'b0, "R10 write strobe with writes disabled", 1, 0);
  end

  task automatic addr_phase(input logic [7:0] hi, input logic [7:0] lo);
    @(negedge clk);
    bus_hi_addr = hi; bus_da_in = lo; bus_as_n = 1'b0;
    repeat (3) @(negedge clk);
    bus_as_n = 1'b1;
    repeat (4) @(negedge clk);
  endtask

  task automatic iaddr_phase(input logic [7:0] v);
    @(negedge clk);
    bus_da_in = v; bus_ias_n = 1'b0;
    repeat (3) @(negedge clk);
    bus_ias_n = 1'b1;
    repeat (4) @(negedge clk);
  endtask

  task automatic write_phase(input logic [7:0] v, input bit expect_take);
    @(negedge clk);
    bus_da_in = v; bus_wr_n = 1'b0; bus_ds_n = 1'b0;
    if (expect_take) exp_q.push_back(v);
    repeat (3) @(negedge clk);
    bus_ds_n = 1'b1;
    repeat (4) @(negedge clk);
    bus_wr_n = 1'b1;
  endtask

  task automatic read_phase(input bit exp_oe);
    @(negedge clk);
    bus_wr_n = 1'b1; bus_ds_n = 1'b0;
    repeat (3) @(negedge clk);
    chk(m_da_oe == exp_oe, "R6 read output enable", m_da_oe, exp_oe);
    if (exp_oe) chk(m_da_out == rd_octet, "R6 read octet", m_da_out, rd_octet);
    chk(n_da_oe == 1'b0, "R10 read drive with reads disabled", n_da_oe, 0);
    bus_ds_n = 1'b1;
    repeat (4) @(negedge clk);
  endtask

  task automatic pulse_line(input bit use_arb);
    @(negedge clk);
    if (use_arb) arb_request_n = 1'b0; else bus_release_n = 1'b0;
    repeat (3) @(negedge clk);
    arb_request_n = 1'b1; bus_release_n = 1'b1;
    repeat (3) @(negedge clk);
  endtask

  task automatic report();
    if (!finished) begin
      finished = 1'b1;
      if (exp_q.size() != 0) chk(1'b0, "R5 missing write strobes", exp_q.size(), 0);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  endtask

  initial begin
    repeat (40000) @(posedge clk);
    failures++;
    checks++;
    $display("FAIL watchdog expired");
    report();
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1: state while reset is held
    chk(!m_active && !m_sub_valid && !m_wr_strobe && !m_rd_done && !m_da_oe,
        "R1 reset outputs", {m_active, m_sub_valid, m_wr_strobe, m_da_oe}, 0);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
    chk(!m_active && !m_sub_valid && !m_da_oe, "R1 after reset",
        {m_active, m_sub_valid, m_da_oe}, 0);

    // R2: wrong upper octet does not select
    addr_phase(8'h00, 8'hA5);
    chk(m_active == 1'b0, "R2 upper octet mismatch", m_active, 0);
    write_phase(8'h11, 1'b0);

    // R11 / R2: cycle of selection after a matching address
    @(negedge clk);
    bus_hi_addr = 8'h12; bus_da_in = 8'hA5; bus_as_n = 1'b0;
    repeat (3) @(negedge clk);
    bus_as_n = 1'b1;
    @(negedge clk);
    chk(m_active == 1'b0, "R11 not active one edge after strobe", m_active, 0);
    @(negedge clk);
    chk(m_active == 1'b0, "R11 not active two edges after strobe", m_active, 0);
    @(negedge clk);
    chk(m_active == 1'b1, "R11 active on third edge", m_active, 1);
    chk(m_active == 1'b1, "R2 wide address match", m_active, 1);
    repeat (2) @(negedge clk);

    // R4: internal address latched by active unit
    iaddr_phase(8'h07);
    chk(m_sub_valid && m_sub_addr == 8'h07, "R4 internal address", m_sub_addr, 8'h07);

    // R5: writes captured
    write_phase(8'h3C, 1'b1);
    write_phase(8'h99, 1'b1);
    // R6: read drive
    read_phase(1'b1);

    // R8: data then internal address replaces it
    iaddr_phase(8'h09);
    chk(m_active && m_sub_valid && m_sub_addr == 8'h09, "R8 internal address replaced",
        m_sub_addr, 8'h09);
    write_phase(8'h44, 1'b1);
    chk(m_sub_addr == 8'h09, "R8 internal address kept over data", m_sub_addr, 8'h09);

    // R7: data then non-matching address ends session
    addr_phase(8'h33, 8'h33);
    chk(m_active == 1'b0, "R7 session ended", m_active, 0);
    chk(m_sub_valid == 1'b0, "R7 internal address released", m_sub_valid, 0);
    write_phase(8'h55, 1'b0);
    read_phase(1'b0);

    // R4: internal address ignored while inactive
    iaddr_phase(8'h21);
    chk(m_sub_valid == 1'b0, "R4 ignored when inactive", m_sub_valid, 0);
    write_phase(8'h56, 1'b0);

    // R3: back-to-back address phases, one matching
    addr_phase(8'h12, 8'hA5);
    addr_phase(8'h44, 8'h44);
    chk(m_active == 1'b1, "R3 multi-address keeps match", m_active, 1);
    iaddr_phase(8'h0B);
    write_phase(8'h66, 1'b1);
    chk(m_sub_addr == 8'h0B, "R4 second internal address", m_sub_addr, 8'h0B);

    // R9: release line
    pulse_line(1'b0);
    chk(!m_active && !m_sub_valid, "R9 release clears", {m_active, m_sub_valid}, 0);
    write_phase(8'h67, 1'b0);

    // R9: arbitration request
    addr_phase(8'h12, 8'hA5);
    chk(m_active == 1'b1, "R2 reselect after release", m_active, 1);
    pulse_line(1'b1);
    chk(m_active == 1'b0, "R9 arbitration request clears", m_active, 0);
    write_phase(8'h68, 1'b0);

    // R2 narrow / R10: capability-limited unit
    addr_phase(8'h77, 8'h5A);
    chk(n_active == 1'b1, "R2 narrow match ignores upper octet", n_active, 1);
    chk(m_active == 1'b0, "R2 other unit not selected", m_active, 0);
    write_phase(8'h12, 1'b0);
    read_phase(1'b0);
    chk(n_active == 1'b1, "R10 unit stays active without capabilities", n_active, 1);

    repeat (4) @(negedge clk);
    report();
  end

endmodule